// File: doc/BRIEF.md
# Buffered Chip-Select Synchronous Serial Port

This block is a clocked synchronous serial port that moves a whole block of bytes in one go. Before a transfer the host fills a small buffer memory, sets a byte count and pulses a start input. The port then works through the buffer from slot 0 upward. For each byte it drives the stored value out on the data output, most significant bit first. At the same time it shifts the serial input into a receive register, and it writes each received byte back into the slot whose byte was just sent. When the last byte is finished the host finds the reply in the same buffer.

The serial clock can come from a divider in the block (master) or from the far side (slave). An external clock is brought onto the system clock through a synchronizer and an edge detector. An active-low chip-select input gates the whole exchange. While it is inactive nothing shifts, and the clock and data output enables are low. If the select is withdrawn in the middle of a byte, the partial byte is dropped. The transfer resumes from the most significant bit of that same byte once the select returns.

Top module: `csport_xfer`

## Requirements
- R1: While the port is idle, a host write (`buf_we`) stores `buf_wdata` at `buf_addr`, and `buf_rdata` always returns the slot at `buf_addr`. Host writes while `busy` is high are ignored.
- R2: A `start` pulse is accepted only while idle and only when `xfer_len` is between 1 and DEPTH. An accepted pulse raises `busy` on the next clock. A count of 0, a count above DEPTH, or a pulse while busy has no effect.
- R3: Bytes go out most significant bit first. `so` changes only on a falling edge of the serial clock, and the first falling edge of each byte presents that byte's bit 7.
- R4: The serial input is sampled on each rising edge of the serial clock. After 8 rising edges the received byte overwrites the buffer slot of the byte just sent, and the slot index then advances.
- R5: In master mode `sck_out` idles high and toggles with a period of exactly SCK_DIV system clocks. It toggles only while busy, with the select active and `so_oe` high.
- R6: In slave mode `sck_oe` stays low. Edges of `sck_in` are found after a SYNC_STAGES-flop synchronizer, so the external clock must stay high and low for at least SYNC_STAGES+2 system clocks each.
- R7: With SYNC_STAGES=2, `sck_oe` (master only) rises 2 clocks after `cs_n_in` falls, and `so_oe` rises SO_LAG clocks after that. Both fall 2 clocks after `cs_n_in` rises, and `sck_out` is then parked high.
- R8: If the select goes inactive in the middle of a byte, the partial byte is discarded and `busy` stays high. The buffer keeps its contents, and the transfer restarts that byte from bit 7 when the select returns.
- R9: `busy` falls on the clock edge that finishes the last byte. `done` is high for exactly that one cycle, and `irq` is set on it. `irq` stays set until an `irq_clr` pulse; if completion and `irq_clr` meet in the same cycle, `irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1: internal serial clock, 0: external serial clock |
| cs_n_in | input | 1 | Active-low chip select |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for the serial data pad |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 5 | Host buffer slot address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer contents at `buf_addr` |
| xfer_len | input | 6 | Number of bytes to transfer (1 to DEPTH) |
| start | input | 1 | Start pulse |
| irq_clr | input | 1 | Clears the sticky completion flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion flag |

## Verification
The bench uses the defaults: a 32-slot buffer of 8-bit bytes, a divider of 8, two synchronizer stages and an output lag of 3. With a divider of 8, a clock period can be measured exactly in system clocks. With two stages, the output enable timing after a select edge can be checked on a known cycle. A 32-slot buffer puts both ends of the count range within reach: a one-slot-too-large count is refused, and a full 32-byte exchange exercises the last slot index. In slave mode the bench drives an external clock of 16 system clocks per period. That leaves room for a pause in the middle of a byte and the restart of that byte.

// File: rtl/csx_pkg.sv
package csx_pkg;

   // engine state of the auto-transfer sequencer
   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

   // smallest legal serial clock divider (two system clocks per half period)
   localparam int unsigned CSX_MIN_DIV = 4;

   // packing order of the synchronized pad bundle
   localparam int unsigned PAD_CS  = 2;
   localparam int unsigned PAD_SCK = 1;
   localparam int unsigned PAD_SI  = 0;
   localparam int unsigned PAD_W   = 3;

endpackage

// File: rtl/csx_sync.sv
module csx_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   // STAGES flops for metastability, one more to expose the previous value
   logic [STAGES:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {(STAGES+1){RST_VAL}};
      end else begin
         chain <= {chain[STAGES-1:0], d};
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = chain[STAGES];

endmodule

// File: rtl/csx_sckgen.sv
module csx_sckgen #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic fall_stb,
   output logic rise_stb
);

   localparam int unsigned HALF = DIV / 2;
   localparam int unsigned PW   = $clog2(DIV);
   localparam bit          POW2 = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] ph;
   logic [PW-1:0] ph_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign ph_nx = ph + 1'b1;
      end else begin : g_wrap_cmp
         assign ph_nx = (ph == PW'(DIV - 1)) ? '0 : ph + 1'b1;
      end
   endgenerate

   assign fall_stb = run && (ph == '0);
   assign rise_stb = run && (ph == PW'(HALF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= '0;
         sck <= 1'b1;
      end else if (!run) begin
         ph  <= '0;
         sck <= 1'b1;
      end else begin
         ph <= ph_nx;
         if (fall_stb) begin
            sck <= 1'b0;
         end else if (rise_stb) begin
            sck <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/csx_shifter.sv
module csx_shifter #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          fall_e,
   input  logic          rise_e,
   input  logic          si_s,
   input  logic [DW-1:0] load_data,
   output logic          so_bit,
   output logic          byte_done,
   output logic [DW-1:0] rx_next
);

   localparam int unsigned CNW = $clog2(DW);

   logic [CNW-1:0] bit_cnt;
   logic [DW-1:0]  tx_q;
   logic [DW-1:0]  rx_q;

   assign rx_next   = {rx_q[DW-2:0], si_s};
   assign byte_done = rise_e && (bit_cnt == CNW'(DW - 1));
   assign so_bit    = tx_q[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
      end else if (clear) begin
         bit_cnt <= '0;
         rx_q    <= '0;
      end else if (fall_e) begin
         if (bit_cnt == '0) begin
            tx_q <= load_data;
         end else begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
         end
      end else if (rise_e) begin
         rx_q <= rx_next;
         if (byte_done) begin
            bit_cnt <= '0;
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/csx_bufram.sv
module csx_bufram #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/csport_xfer.sv
module csport_xfer #(
   parameter int unsigned DEPTH       = 32,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SCK_DIV     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SO_LAG      = 3,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_master,
   input  logic              cs_n_in,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   input  logic              buf_we,
   input  logic [AW-1:0]     buf_addr,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic [DATA_W-1:0] buf_rdata,
   input  logic [CW-1:0]     xfer_len,
   input  logic              start,
   input  logic              irq_clr,
   output logic              busy,
   output logic              done,
   output logic              irq
);

   import csx_pkg::*;

   localparam int unsigned LW = $clog2(SO_LAG + 1);

   // elaboration-time parameter checks
   generate
      if (SCK_DIV < CSX_MIN_DIV || (SCK_DIV % 2) != 0) begin : g_bad_div
         $error("SCK_DIV must be even and at least 4");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SO_LAG < 1) begin : g_bad_lag
         $error("SO_LAG must be at least 1");
      end
   endgenerate

   // ---------------- pad synchronizer ----------------
   logic [PAD_W-1:0] pad_raw, pad_s, pad_p;

   assign pad_raw[PAD_CS]  = cs_n_in;
   assign pad_raw[PAD_SCK] = sck_in;
   assign pad_raw[PAD_SI]  = si;

   csx_sync #(
      .WIDTH   (PAD_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pad_raw),
      .q      (pad_s),
      .q_prev (pad_p)
   );

   logic cs_act, si_s, ext_fall, ext_rise;

   assign cs_act   = ~pad_s[PAD_CS];
   assign si_s     = pad_s[PAD_SI];
   assign ext_fall = pad_p[PAD_SCK] & ~pad_s[PAD_SCK];
   assign ext_rise = ~pad_p[PAD_SCK] & pad_s[PAD_SCK];

   // ---------------- output enable sequencing ----------------
   logic [LW-1:0] lag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lag_q <= '0;
      end else if (!cs_act) begin
         lag_q <= '0;
      end else if (lag_q != LW'(SO_LAG)) begin
         lag_q <= lag_q + 1'b1;
      end
   end

   assign so_oe  = cs_act && (lag_q == LW'(SO_LAG));
   assign sck_oe = mode_master && cs_act;

   // ---------------- engine state ----------------
   eng_state_e      st_q;
   logic [AW-1:0]   idx_q;
   logic [CW-1:0]   len_q;
   logic            start_ok, link_on, last_byte, finish;

   assign busy     = (st_q == ENG_RUN);
   assign link_on  = busy && cs_act;
   assign start_ok = start && !busy && (xfer_len != '0) && (xfer_len <= CW'(DEPTH));

   // ---------------- serial clock sources ----------------
   logic gen_run, gen_fall, gen_rise, fall_e, rise_e;

   assign gen_run = mode_master && link_on && so_oe;

   csx_sckgen #(
      .DIV (SCK_DIV)
   ) u_sckgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (gen_run),
      .sck      (sck_out),
      .fall_stb (gen_fall),
      .rise_stb (gen_rise)
   );

   assign fall_e = link_on && (mode_master ? gen_fall : ext_fall);
   assign rise_e = link_on && (mode_master ? gen_rise : ext_rise);

   // ---------------- shifter ----------------
   logic [DATA_W-1:0] eng_rdata, rx_next;
   logic              byte_done;

   csx_shifter #(
      .DW (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (!link_on),
      .fall_e    (fall_e),
      .rise_e    (rise_e),
      .si_s      (si_s),
      .load_data (eng_rdata),
      .so_bit    (so),
      .byte_done (byte_done),
      .rx_next   (rx_next)
   );

   assign last_byte = ((CW'(idx_q) + CW'(1)) == len_q);
   assign finish    = byte_done && last_byte;

   // ---------------- buffer memory ----------------
   logic              mem_we;
   logic [AW-1:0]     mem_waddr;
   logic [DATA_W-1:0] mem_wdata;

   assign mem_we    = busy ? byte_done : buf_we;
   assign mem_waddr = busy ? idx_q     : buf_addr;
   assign mem_wdata = busy ? rx_next   : buf_wdata;

   csx_bufram #(
      .DEPTH (DEPTH),
      .DW    (DATA_W)
   ) u_buf (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (mem_waddr),
      .wdata   (mem_wdata),
      .raddr_a (buf_addr),
      .rdata_a (buf_rdata),
      .raddr_b (idx_q),
      .rdata_b (eng_rdata)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ENG_IDLE;
         idx_q <= '0;
         len_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_ok) begin
            st_q  <= ENG_RUN;
            idx_q <= '0;
            len_q <= xfer_len;
         end else if (busy && byte_done) begin
            if (last_byte) begin
               st_q <= ENG_IDLE;
               done <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (finish) begin
         irq <= 1'b1;
      end else if (irq_clr) begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/csx_port_chk.sv
module csx_port_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_master,
   input logic start,
   input logic irq_clr,
   input logic busy,
   input logic done,
   input logic irq,
   input logic sck_out,
   input logic sck_oe,
   input logic so_oe
);

   AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2

   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && irq)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R9

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq); // R9

   AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out); // R5

   AST_SCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_oe |=> sck_out); // R7

   AST_SO_AFTER_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_master && so_oe) |-> sck_oe); // R7

   AST_SLAVE_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_master |-> !sck_oe); // R6

endmodule

bind csport_xfer csx_port_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_master (mode_master),
   .start       (start),
   .irq_clr     (irq_clr),
   .busy        (busy),
   .done        (done),
   .irq         (irq),
   .sck_out     (sck_out),
   .sck_oe      (sck_oe),
   .so_oe       (so_oe)
);

// File: tb/csport_xfer_tb.sv
module csport_xfer_tb;

   localparam int DEPTH = 32;

   logic       clk, rst_n;
   logic       mode_master, cs_n_in, sck_in, si;
   logic       sck_out, sck_oe, so, so_oe;
   logic       buf_we;
   logic [4:0] buf_addr;
   logic [7:0] buf_wdata, buf_rdata;
   logic [5:0] xfer_len;
   logic       start, irq_clr;
   logic       busy, done, irq;

   csport_xfer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_master (mode_master),
      .cs_n_in     (cs_n_in),
      .sck_in      (sck_in),
      .sck_out     (sck_out),
      .sck_oe      (sck_oe),
      .si          (si),
      .so          (so),
      .so_oe       (so_oe),
      .buf_we      (buf_we),
      .buf_addr    (buf_addr),
      .buf_wdata   (buf_wdata),
      .buf_rdata   (buf_rdata),
      .xfer_len    (xfer_len),
      .start       (start),
      .irq_clr     (irq_clr),
      .busy        (busy),
      .done        (done),
      .irq         (irq)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int n_chk = 0;
   int n_bad = 0;
   int done_seen = 0;

   always @(negedge clk) if (rst_n && done) done_seen++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      buf_we = 1'b1; buf_addr = a; buf_wdata = d;
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      buf_addr = a;
      #1 d = buf_rdata;
   endtask

   task automatic pulse_start(input logic [5:0] n);
      @(negedge clk);
      xfer_len = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // one external clock period in slave mode: low half then high half
   task automatic sl_bit(input logic din, output logic dout);
      sck_in = 1'b0;
      idle(8);
      dout = so;
      si = din;
      sck_in = 1'b1;
      idle(8);
   endtask

   task automatic t_reset;
      chk("R9 busy after reset", busy, 0);
      chk("R9 irq after reset", irq, 0);
      chk("R5 sck idle high", sck_out, 1);
      chk("R7 sck_oe after reset", sck_oe, 0);
      chk("R7 so_oe after reset", so_oe, 0);
   endtask

   task automatic t_host_buf;
      logic [7:0] d;
      wr(5'd3, 8'h5E);
      wr(5'd31, 8'hC1);
      rd(5'd3, d);  chk("R1 readback slot 3", d, 8'h5E);
      rd(5'd31, d); chk("R1 readback slot 31", d, 8'hC1);
   endtask

   task automatic t_bad_start;
      cs_n_in = 1'b0;
      pulse_start(6'd0);
      idle(2);
      chk("R2 zero count refused", busy, 0);
      pulse_start(6'd33);
      idle(2);
      chk("R2 over-range count refused", busy, 0);
      cs_n_in = 1'b1;
      idle(4);
   endtask

   task automatic t_cs_enables;
      mode_master = 1'b1;
      cs_n_in = 1'b1;
      idle(4);
      cs_n_in = 1'b0;
      idle(3);
      chk("R7 sck_oe after 2 clocks", sck_oe, 1);
      chk("R7 so_oe still low", so_oe, 0);
      idle(3);
      chk("R7 so_oe after lag", so_oe, 1);
      cs_n_in = 1'b1;
      idle(3);
      chk("R7 sck_oe off on cs high", sck_oe, 0);
      chk("R7 so_oe off on cs high", so_oe, 0);
      chk("R7 sck parked high", sck_out, 1);
      mode_master = 1'b0;
      cs_n_in = 1'b0;
      idle(6);
      chk("R6 slave keeps sck_oe low", sck_oe, 0);
      chk("R7 so_oe in slave mode", so_oe, 1);
      cs_n_in = 1'b1;
      idle(4);
   endtask

   task automatic t_master(input int len, input int seed);
      logic [7:0] orig [DEPTH];
      logic [7:0] resp [DEPTH];
      logic [7:0] got  [DEPTH];
      logic [7:0] d;
      time t0, t1;
      int d0;
      t0 = 0; t1 = 0;
      for (int i = 0; i < len; i++) begin
         orig[i] = 8'(i * 37 + seed);
         resp[i] = 8'(i * 91 + 3 * seed + 1);
         got[i]  = 8'h00;
         wr(5'(i), orig[i]);
      end
      mode_master = 1'b1;
      cs_n_in = 1'b0;
      idle(8);
      d0 = done_seen;
      pulse_start(6'(len));
      chk("R2 start accepted", busy, 1);
      for (int b = 0; b < len; b++) begin
         for (int k = 7; k >= 0; k--) begin
            @(negedge sck_out);
            if (b == 0 && k == 7) t0 = $time;
            if (b == 0 && k == 6) t1 = $time;
            #1 si = resp[b][k];
            @(posedge sck_out);
            #1 got[b][k] = so;
         end
      end
      idle(6);
      chk("R9 busy cleared", busy, 0);
      chk("R9 irq set", irq, 1);
      chk("R9 one done pulse", done_seen - d0, 1);
      chk("R5 sck period in clocks", 32'((t1 - t0) / 8), 8);
      for (int b = 0; b < len; b++) begin
         chk("R3 MSB-first byte on so", got[b], orig[b]);
         rd(5'(b), d);
         chk("R4 reply stored in slot", d, resp[b]);
      end
      cs_n_in = 1'b1;
      idle(4);
   endtask

   task automatic t_irq_clear;
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R9 irq cleared by host", irq, 0);
   endtask

   task automatic t_slave_pause;
      logic [7:0] orig [2];
      logic [7:0] resp [2];
      logic [7:0] got  [2];
      logic [7:0] d;
      logic       junk;
      orig[0] = 8'hB4; orig[1] = 8'h69;
      resp[0] = 8'h2D; resp[1] = 8'hE7;
      wr(5'd0, orig[0]);
      wr(5'd1, orig[1]);
      wr(5'd5, 8'h3C);
      mode_master = 1'b0;
      sck_in = 1'b1;
      cs_n_in = 1'b0;
      idle(8);
      pulse_start(6'd2);
      for (int k = 0; k < 4; k++) sl_bit(1'b1, junk);
      cs_n_in = 1'b1;
      idle(6);
      chk("R8 busy held in pause", busy, 1);
      chk("R7 so_oe low in pause", so_oe, 0);
      rd(5'd0, d);
      chk("R8 slot kept in pause", d, orig[0]);
      wr(5'd5, 8'h77);
      cs_n_in = 1'b0;
      idle(8);
      for (int b = 0; b < 2; b++) begin
         for (int k = 7; k >= 0; k--) begin
            sl_bit(resp[b][k], got[b][k]);
         end
      end
      idle(6);
      chk("R9 slave transfer finished", busy, 0);
      for (int b = 0; b < 2; b++) begin
         chk("R8 byte restarted from bit 7", got[b], orig[b]);
         rd(5'(b), d);
         chk("R6 slave reply stored", d, resp[b]);
      end
      rd(5'd5, d);
      chk("R1 busy host write ignored", d, 8'h3C);
      cs_n_in = 1'b1;
      idle(4);
   endtask

   initial begin
      rst_n = 1'b0;
      mode_master = 1'b1; cs_n_in = 1'b1; sck_in = 1'b1; si = 1'b0;
      buf_we = 1'b0; buf_addr = '0; buf_wdata = '0;
      xfer_len = '0; start = 1'b0; irq_clr = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_host_buf();
      t_bad_start();
      t_cs_enables();
      t_master(3, 5);
      t_irq_clear();
      t_slave_pause();
      t_irq_clear();
      t_master(32, 11);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule